// File: doc/BRIEF.md
# Parallel-Bus FPGA Configuration Loader

This block loads a configuration image into a downstream FPGA over an 8-bit parallel slave configuration bus. A pulse on `start` begins the load. The block pulls the device's program line low for a fixed number of cycles. It then waits until the device shows it has cleared its memory and is not busy. Next it opens the write window in three steps: write enable, then chip select, then a first high level on the configuration clock.

Image bytes come in on a valid/ready stream, one byte per configuration-clock period. A byte is only taken while the clock is high. It is driven onto the data bus during the following low phase and stays there through the rising edge that follows. The byte flagged as last closes the window: chip select is released first, then write enable. After that the block keeps toggling the configuration clock until the device raises its done line. The load then ends with `ok`. If a wait exceeds its cycle limit, the load ends with `err`.

When the elaboration parameter `BUSY_CHECK` is set, a busy indication after a rising edge makes the block repeat the clock pulse with the same byte held on the bus. The repeats are bounded by the same cycle limit.

Top module: `par_cfg_loader`

State names used below: IDLE, PROG (program pulse), RDY (ready wait), WRON, CSON, CKUP (window opening), PUT (take byte, clock high), CKLO (clock low), CKHI (clock high, decide), CSOFF, WROFF (window closing), DNLO, DNHI (done clocking).

Transitions:
- IDLE→PROG on `start`.
- PROG→RDY after `PROG_CYCLES`.
- RDY→WRON when ready.
- WRON→CSON→CKUP→PUT, one cycle each.
- PUT→CKLO when a byte is taken.
- CKLO→CKHI.
- CKHI→CKLO on a busy retry. CKHI→PUT for the next byte. CKHI→CSOFF after the last byte.
- CSOFF→WROFF.
- WROFF→IDLE if done is high, otherwise WROFF→DNLO.
- DNLO→DNHI.
- DNHI→IDLE if done is high, otherwise DNHI→DNLO.
- Any timeout→IDLE with the abort flag set.

## Requirements
- R1: After reset: `prog_n`, `csel_n` and `wr_n` are 1, `cclk` is 0, `s_ready`, `active`, `ok` and `err` are 0, and `dbus` is 0.
- R2: `start` sampled high in IDLE drives `prog_n` low from the next cycle for exactly `PROG_CYCLES` cycles, and clears `ok` and `err` in that same cycle.
- R3: Once `prog_n` is high again, `wr_n` stays high until `dev_init_n`=1 and `dev_busy`=0 are sampled together. If that has not happened within `TMO_CYCLES` cycles, the load aborts.
- R4: The write window opens in this order: `wr_n` falls, `csel_n` falls in the next cycle, and `cclk` rises in the cycle after that.
- R5: `s_ready` is high only while `cclk` is 1 and `csel_n` is 0. A byte taken (`s_valid`&`s_ready` at an edge) is on `dbus` in the next cycle with `cclk` 0, and stays there through the following rising edge. Bytes reach `dbus` in stream order. Without busy there is exactly one rising edge per byte, plus the opening edge.
- R6: With `BUSY_CHECK`=1, `dev_busy`=1 sampled in a clock-high decision cycle repeats a low/high pulse with `dbus` unchanged, and no byte is taken. A retry run longer than `TMO_CYCLES` aborts the load.
- R7: After the clock pulse of the byte with `s_last`=1, `csel_n` rises, and `wr_n` rises one cycle later.
- R8: After the window closes, `cclk` alternates one cycle high and one cycle low until `dev_done`=1 is sampled in a high cycle. The block then returns to IDLE with `ok`=1.
- R9: If `dev_done` does not rise within `TMO_CYCLES` cycles of done clocking, the load aborts.
- R10: An abort returns to IDLE with `prog_n`, `csel_n` and `wr_n` high. `err`=1 and `ok`=0 hold until the next accepted `start`.
- R11: `start` while `active`=1 has no effect on the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a load (sampled in IDLE only) |
| s_data | input | DW | Image byte |
| s_valid | input | 1 | Image byte valid |
| s_last | input | 1 | Marks the final image byte |
| s_ready | output | 1 | Byte taken at this edge when valid |
| dev_init_n | input | 1 | Device clear-complete line, 1 = ready |
| dev_busy | input | 1 | Device busy line, 1 = busy |
| dev_done | input | 1 | Device configuration done |
| prog_n | output | 1 | Device program line, active low |
| csel_n | output | 1 | Device chip select, active low |
| wr_n | output | 1 | Device write enable, active low |
| cclk | output | 1 | Configuration clock |
| dbus | output | DW | Configuration data bus |
| active | output | 1 | A load is in progress |
| ok | output | 1 | Last load finished with done high (sticky) |
| err | output | 1 | Last load aborted on a timeout (sticky) |

## Verification
All pin outputs are decoded directly from the state register, so a wrong state is visible on the device pins in the same cycle it is entered. A skipped or extra state shows up as an early or late edge on `wr_n`, `csel_n` or `cclk`, or as `s_ready` appearing outside a clock-high cycle. A corrupted byte register shows on `dbus` in the low phase right after the transfer. A counter that ends early or late moves the program pulse edge, or the abort, by the same number of cycles. The bench compares every pin on every cycle against a behavioural model, so each of these faults is caught at the first cycle it differs.

// File: rtl/par_cfg_pkg.sv
package par_cfg_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PROG,
        ST_RDY,
        ST_WRON,
        ST_CSON,
        ST_CKUP,
        ST_PUT,
        ST_CKLO,
        ST_CKHI,
        ST_CSOFF,
        ST_WROFF,
        ST_DNLO,
        ST_DNHI
    } cfg_state_e;

endpackage

// File: rtl/par_cfg_timer.sv
module par_cfg_timer #(
    parameter int unsigned LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic hit
);
    localparam int unsigned CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    // counts cycles spent with run high; saturates at the last count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign hit = run && (cnt == LAST);

endmodule

// File: rtl/par_cfg_seq.sv
module par_cfg_seq
    import par_cfg_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [DW-1:0] s_data,
    input  logic          s_valid,
    input  logic          s_last,
    output logic          s_ready,
    input  logic          dev_init_n,
    input  logic          dev_busy,
    input  logic          throttle_busy,
    input  logic          dev_done,
    input  logic          prog_hit,
    input  logic          tmo_hit,
    output logic          prog_run,
    output logic          tmo_run,
    output logic          prog_n,
    output logic          csel_n,
    output logic          wr_n,
    output logic          cclk,
    output logic [DW-1:0] dbus,
    output logic          active,
    output logic          ok,
    output logic          err
);
    cfg_state_e state, state_d;
    logic       take, set_ok, set_err, clr_flags;
    logic       last_q;

    // next-state selection
    always_comb begin
        state_d   = state;
        take      = 1'b0;
        set_ok    = 1'b0;
        set_err   = 1'b0;
        clr_flags = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    state_d   = ST_PROG;
                    clr_flags = 1'b1;
                end
            end
            ST_PROG: begin
                if (prog_hit) state_d = ST_RDY;
            end
            ST_RDY: begin
                if (dev_init_n && !dev_busy) begin
                    state_d = ST_WRON;
                end else if (tmo_hit) begin
                    state_d = ST_IDLE;
                    set_err = 1'b1;
                end
            end
            ST_WRON:  state_d = ST_CSON;
            ST_CSON:  state_d = ST_CKUP;
            ST_CKUP:  state_d = ST_PUT;
            ST_PUT: begin
                if (s_valid) begin
                    take    = 1'b1;
                    state_d = ST_CKLO;
                end
            end
            ST_CKLO:  state_d = ST_CKHI;
            ST_CKHI: begin
                if (throttle_busy) begin
                    if (tmo_hit) begin
                        state_d = ST_IDLE;
                        set_err = 1'b1;
                    end else begin
                        state_d = ST_CKLO;
                    end
                end else if (last_q) begin
                    state_d = ST_CSOFF;
                end else begin
                    state_d = ST_PUT;
                end
            end
            ST_CSOFF: state_d = ST_WROFF;
            ST_WROFF: begin
                if (dev_done) begin
                    state_d = ST_IDLE;
                    set_ok  = 1'b1;
                end else begin
                    state_d = ST_DNLO;
                end
            end
            ST_DNLO:  state_d = ST_DNHI;
            ST_DNHI: begin
                if (dev_done) begin
                    state_d = ST_IDLE;
                    set_ok  = 1'b1;
                end else if (tmo_hit) begin
                    state_d = ST_IDLE;
                    set_err = 1'b1;
                end else begin
                    state_d = ST_DNLO;
                end
            end
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    // byte holding register and sticky result flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dbus   <= '0;
            last_q <= 1'b0;
            ok     <= 1'b0;
            err    <= 1'b0;
        end else begin
            if (take) begin
                dbus   <= s_data;
                last_q <= s_last;
            end
            if (clr_flags) begin
                ok  <= 1'b0;
                err <= 1'b0;
            end else begin
                if (set_ok)  ok  <= 1'b1;
                if (set_err) err <= 1'b1;
            end
        end
    end

    // pin and timer controls, decoded from the state alone
    always_comb begin
        prog_n   = 1'b1;
        csel_n   = 1'b1;
        wr_n     = 1'b1;
        cclk     = 1'b0;
        s_ready  = 1'b0;
        prog_run = 1'b0;
        tmo_run  = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_PROG: begin
                prog_n   = 1'b0;
                prog_run = 1'b1;
            end
            ST_RDY:   tmo_run = 1'b1;
            ST_WRON:  wr_n = 1'b0;
            ST_CSON: begin
                wr_n   = 1'b0;
                csel_n = 1'b0;
            end
            ST_CKUP: begin
                wr_n   = 1'b0;
                csel_n = 1'b0;
                cclk   = 1'b1;
            end
            ST_PUT: begin
                wr_n    = 1'b0;
                csel_n  = 1'b0;
                cclk    = 1'b1;
                s_ready = 1'b1;
            end
            ST_CKLO: begin
                wr_n    = 1'b0;
                csel_n  = 1'b0;
                tmo_run = 1'b1;
            end
            ST_CKHI: begin
                wr_n    = 1'b0;
                csel_n  = 1'b0;
                cclk    = 1'b1;
                tmo_run = 1'b1;
            end
            ST_CSOFF: begin
                wr_n = 1'b0;
                cclk = 1'b1;
            end
            ST_WROFF: cclk = 1'b1;
            ST_DNLO:  tmo_run = 1'b1;
            ST_DNHI: begin
                cclk    = 1'b1;
                tmo_run = 1'b1;
            end
            default: ;
        endcase
    end

    assign active = (state != ST_IDLE);

endmodule

// File: rtl/par_cfg_loader.sv
module par_cfg_loader #(
    parameter int unsigned DW          = 8,
    parameter int unsigned PROG_CYCLES = 64,
    parameter int unsigned TMO_CYCLES  = 2500000,
    parameter bit          BUSY_CHECK  = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [DW-1:0] s_data,
    input  logic          s_valid,
    input  logic          s_last,
    output logic          s_ready,
    input  logic          dev_init_n,
    input  logic          dev_busy,
    input  logic          dev_done,
    output logic          prog_n,
    output logic          csel_n,
    output logic          wr_n,
    output logic          cclk,
    output logic [DW-1:0] dbus,
    output logic          active,
    output logic          ok,
    output logic          err
);
    logic prog_run, prog_hit, tmo_run, tmo_hit, throttle_busy;

    generate
        if (BUSY_CHECK) begin : g_throttle
            assign throttle_busy = dev_busy;
        end else begin : g_free_run
            assign throttle_busy = 1'b0;
        end
    endgenerate

    par_cfg_timer #(.LIMIT(PROG_CYCLES)) u_prog_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (prog_run),
        .hit   (prog_hit)
    );

    par_cfg_timer #(.LIMIT(TMO_CYCLES)) u_wait_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (tmo_run),
        .hit   (tmo_hit)
    );

    par_cfg_seq #(.DW(DW)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .s_data        (s_data),
        .s_valid       (s_valid),
        .s_last        (s_last),
        .s_ready       (s_ready),
        .dev_init_n    (dev_init_n),
        .dev_busy      (dev_busy),
        .throttle_busy (throttle_busy),
        .dev_done      (dev_done),
        .prog_hit      (prog_hit),
        .tmo_hit       (tmo_hit),
        .prog_run      (prog_run),
        .tmo_run       (tmo_run),
        .prog_n        (prog_n),
        .csel_n        (csel_n),
        .wr_n          (wr_n),
        .cclk          (cclk),
        .dbus          (dbus),
        .active        (active),
        .ok            (ok),
        .err           (err)
    );

endmodule

// File: rtl/par_cfg_loader_chk.sv
module par_cfg_loader_chk #(
    parameter int unsigned DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [DW-1:0] s_data,
    input logic          s_valid,
    input logic          s_last,
    input logic          s_ready,
    input logic          dev_init_n,
    input logic          dev_busy,
    input logic          dev_done,
    input logic          prog_n,
    input logic          csel_n,
    input logic          wr_n,
    input logic          cclk,
    input logic [DW-1:0] dbus,
    input logic          active,
    input logic          ok,
    input logic          err
);
    logic unused_last;
    assign unused_last = s_last;

    assert_prog_from_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prog_n) |-> $past(start) && !$past(active) && !ok && !err);

    assert_ready_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_n) |-> $past(dev_init_n) && !$past(dev_busy));

    assert_open_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(csel_n) |-> !wr_n && !$past(wr_n));

    assert_ready_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |-> cclk && !csel_n && !wr_n);

    assert_byte_driven_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_ready) |=> !cclk && (dbus == $past(s_data)));

    assert_bus_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dbus) |-> $past(s_valid && s_ready));

    assert_close_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(wr_n) && active) |-> $past(csel_n));

    assert_ok_on_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ok) |-> $past(dev_done));

    assert_abort_state_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !active && prog_n && csel_n && wr_n && !ok);

endmodule

bind par_cfg_loader par_cfg_loader_chk #(.DW(DW)) u_chk (.*);

// File: tb/par_cfg_loader_tb.sv
`timescale 1ns/1ps
module par_cfg_loader_tb;
    localparam int PROG_CYC = 4;
    localparam int TMO      = 30;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] s_data = 8'h00;
    logic       s_valid = 1'b0;
    logic       s_last = 1'b0;
    logic       s_ready;
    logic       dev_init_n = 1'b0;
    logic       dev_busy = 1'b1;
    logic       dev_done = 1'b0;
    logic       prog_n, csel_n, wr_n, cclk, active, ok, err;
    logic [7:0] dbus;

    always #2 clk = ~clk;

    par_cfg_loader #(.DW(8), .PROG_CYCLES(PROG_CYC), .TMO_CYCLES(TMO), .BUSY_CHECK(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .s_data(s_data), .s_valid(s_valid),
        .s_last(s_last), .s_ready(s_ready), .dev_init_n(dev_init_n), .dev_busy(dev_busy),
        .dev_done(dev_done), .prog_n(prog_n), .csel_n(csel_n), .wr_n(wr_n), .cclk(cclk),
        .dbus(dbus), .active(active), .ok(ok), .err(err)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    localparam int M_IDLE = 0, M_PROG = 1, M_RDY = 2, M_WRON = 3, M_CSON = 4, M_CKUP = 5,
                   M_PUT = 6, M_LO = 7, M_HI = 8, M_CSOFF = 9, M_WROFF = 10, M_DLO = 11, M_DHI = 12;
    int mph, nxt, mdw;
    logic [7:0] mdata;
    logic mlast, mok, merr;

    function automatic int grp(input int p);
        if (p == M_PROG) return 1;
        if (p == M_RDY) return 2;
        if (p == M_LO || p == M_HI) return 3;
        if (p == M_DLO || p == M_DHI) return 4;
        return 0;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mph = M_IDLE; mdw = 0; mdata = 8'h00; mlast = 1'b0; mok = 1'b0; merr = 1'b0;
        end else begin
            nxt = mph;
            case (mph)
                M_IDLE:  if (start) begin nxt = M_PROG; mok = 1'b0; merr = 1'b0; end
                M_PROG:  if (mdw >= PROG_CYC - 1) nxt = M_RDY;
                M_RDY: begin
                    if (dev_init_n && !dev_busy) nxt = M_WRON;
                    else if (mdw >= TMO - 1) begin nxt = M_IDLE; merr = 1'b1; end
                end
                M_WRON:  nxt = M_CSON;
                M_CSON:  nxt = M_CKUP;
                M_CKUP:  nxt = M_PUT;
                M_PUT:   if (s_valid) begin mdata = s_data; mlast = s_last; nxt = M_LO; end
                M_LO:    nxt = M_HI;
                M_HI: begin
                    if (dev_busy) begin
                        if (mdw >= TMO - 1) begin nxt = M_IDLE; merr = 1'b1; end
                        else nxt = M_LO;
                    end else if (mlast) nxt = M_CSOFF;
                    else nxt = M_PUT;
                end
                M_CSOFF: nxt = M_WROFF;
                M_WROFF: if (dev_done) begin nxt = M_IDLE; mok = 1'b1; end else nxt = M_DLO;
                M_DLO:   nxt = M_DHI;
                M_DHI: begin
                    if (dev_done) begin nxt = M_IDLE; mok = 1'b1; end
                    else if (mdw >= TMO - 1) begin nxt = M_IDLE; merr = 1'b1; end
                    else nxt = M_DLO;
                end
                default: nxt = M_IDLE;
            endcase
            if (grp(nxt) != 0 && grp(nxt) == grp(mph)) mdw++;
            else mdw = 0;
            mph = nxt;
        end
    end

    // per-cycle comparison, away from the active edge
    int prog_low = 0, rises = 0, wr_falls = 0;
    logic prev_cclk = 1'b0, prev_wr = 1'b1;
    always @(negedge clk) begin
        if (rst_n) begin
            bit bad;
            bad = 1'b0;
            if (prog_n !== (mph != M_PROG)) begin bad = 1'b1;
                $display("FAIL R2 prog_n actual=%0b expected=%0b at %0t", prog_n, mph != M_PROG, $time); end
            if (wr_n !== !(mph >= M_WRON && mph <= M_CSOFF)) begin bad = 1'b1;
                $display("FAIL R7 wr_n actual=%0b expected=%0b at %0t", wr_n, !(mph >= M_WRON && mph <= M_CSOFF), $time); end
            if (csel_n !== !(mph >= M_CSON && mph <= M_HI)) begin bad = 1'b1;
                $display("FAIL R4 csel_n actual=%0b expected=%0b at %0t", csel_n, !(mph >= M_CSON && mph <= M_HI), $time); end
            if (cclk !== (mph inside {M_CKUP, M_PUT, M_HI, M_CSOFF, M_WROFF, M_DHI})) begin bad = 1'b1;
                $display("FAIL R5 cclk actual=%0b expected=%0b at %0t", cclk,
                         mph inside {M_CKUP, M_PUT, M_HI, M_CSOFF, M_WROFF, M_DHI}, $time); end
            if (s_ready !== (mph == M_PUT)) begin bad = 1'b1;
                $display("FAIL R6 s_ready actual=%0b expected=%0b at %0t", s_ready, mph == M_PUT, $time); end
            if (dbus !== mdata) begin bad = 1'b1;
                $display("FAIL R5 dbus actual=%0h expected=%0h at %0t", dbus, mdata, $time); end
            if (active !== (mph != M_IDLE)) begin bad = 1'b1;
                $display("FAIL R11 active actual=%0b expected=%0b at %0t", active, mph != M_IDLE, $time); end
            if (ok !== mok) begin bad = 1'b1;
                $display("FAIL R8 ok actual=%0b expected=%0b at %0t", ok, mok, $time); end
            if (err !== merr) begin bad = 1'b1;
                $display("FAIL R10 err actual=%0b expected=%0b at %0t", err, merr, $time); end
            checks++;
            if (bad) errors++;
            if (!prog_n) prog_low++;
            if (cclk && !prev_cclk && !csel_n) rises++;
            if (!wr_n && prev_wr) wr_falls++;
        end
        prev_cclk = cclk;
        prev_wr   = wr_n;
    end

    // ---------------- byte stream source ----------------
    logic [7:0] tx_q[$];
    logic [7:0] acc_q[$];
    int  tx_idx = 0, gcnt = 0, gap_mode = 0;
    bit  feed_en = 1'b0, pend = 1'b0;
    always @(negedge clk) begin
        if (pend) begin
            acc_q.push_back(tx_q[tx_idx]);
            tx_idx++;
        end
        gcnt++;
        if (feed_en && tx_idx < tx_q.size() && !(gap_mode == 1 && (gcnt % 3) != 0)) begin
            s_valid = 1'b1;
            s_data  = tx_q[tx_idx];
            s_last  = (tx_idx == tx_q.size() - 1);
        end else begin
            s_valid = 1'b0;
            s_data  = 8'hA5;
            s_last  = 1'b0;
        end
        pend = s_valid && s_ready;
    end

    // ---------------- one load with a scripted device ----------------
    task automatic do_load(input int n, input int gmode, input int init_delay, input bit init_never,
                           input int busy_after, input int busy_len, input int done_delay,
                           input bit poke_start, input bit exp_ok);
        tx_q.delete();
        acc_q.delete();
        for (int k = 0; k < n; k++) tx_q.push_back(8'((k * 37 + 8'h1D) ^ (n << 4)));
        tx_idx = 0; gap_mode = gmode;
        dev_init_n = 1'b0; dev_busy = 1'b1; dev_done = 1'b0;
        prog_low = 0; rises = 0; wr_falls = 0;
        feed_en = 1'b1;
        @(negedge clk); start = 1'b1;
        @(negedge clk);
        chk("R2 flags cleared by start", ok | err, 0);
        start = 1'b0;
        if (init_never) begin
            while (active) @(negedge clk);
        end else begin
            repeat (init_delay) @(negedge clk);
            dev_init_n = 1'b1; dev_busy = 1'b0;
        end
        if (poke_start) begin
            @(negedge clk); start = 1'b1;
            @(negedge clk); start = 1'b0;
        end
        if (busy_len > 0) begin
            while (active && acc_q.size() < busy_after) @(negedge clk);
            dev_busy = 1'b1;
            for (int k = 0; k < busy_len && active; k++) @(negedge clk);
            dev_busy = 1'b0;
        end
        while (active && !(wr_n && csel_n && acc_q.size() == n && !pend)) @(negedge clk);
        if (active && done_delay >= 0) begin
            repeat (done_delay) @(negedge clk);
            dev_done = 1'b1;
        end
        while (active) @(negedge clk);
        @(negedge clk);
        feed_en = 1'b0;
        chk("R8/R10 ok after load", ok, exp_ok);
        chk("R10 err after load", err, !exp_ok);
        chk("R2 program pulse length", prog_low, PROG_CYC);
        if (exp_ok) begin
            chk("R5 byte count delivered", acc_q.size(), n);
            for (int k = 0; k < n && k < acc_q.size(); k++)
                chk("R5 byte order", acc_q[k], tx_q[k]);
        end
    endtask

    // ---------------- watchdog ----------------
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected<=100000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 prog_n", prog_n, 1);
        chk("R1 csel_n", csel_n, 1);
        chk("R1 wr_n", wr_n, 1);
        chk("R1 cclk", cclk, 0);
        chk("R1 active", active, 0);
        chk("R1 ok/err", ok | err, 0);
        chk("R1 dbus", dbus, 0);

        // plain load, no stalls
        do_load(5, 0, 8, 1'b0, 0, 0, 3, 1'b0, 1'b1);
        chk("R5 one rising edge per byte plus opening", rises, 6);
        chk("R4 write enable fell once", wr_falls, 1);

        // gaps in the stream, stray start mid-load (R11)
        do_load(7, 1, 3, 1'b0, 0, 0, 0, 1'b1, 1'b1);
        chk("R11 stray start did not restart", rises, 8);

        // busy throttling with recovery (R6)
        do_load(6, 0, 5, 1'b0, 2, 5, 6, 1'b0, 1'b1);
        chk("R6 extra pulses while busy", int'(rises > 7), 1);

        // device never becomes ready (R3)
        do_load(3, 0, 0, 1'b1, 0, 0, 0, 1'b0, 1'b0);
        chk("R3 window never opened", wr_falls, 0);

        // busy stuck during data (R6 timeout)
        do_load(4, 0, 2, 1'b0, 2, 1000, 0, 1'b0, 1'b0);
        chk("R6 stuck busy aborted before all bytes", int'(acc_q.size() < 4), 1);

        // done never rises (R9)
        do_load(3, 0, 2, 1'b0, 0, 0, -1, 1'b0, 1'b0);
        chk("R9 all bytes sent before done timeout", acc_q.size(), 3);
        chk("R10 pins released after abort", {prog_n, csel_n, wr_n}, 3'b111);

        // recovery after an abort (R2 clears err)
        do_load(2, 0, 1, 1'b0, 0, 0, 2, 1'b0, 1'b1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule